// File: doc/BRIEF.md
# Reference-Locked Oscillator Trim Loop

This block holds a free-running, digitally tuned fast oscillator close to a chosen frequency, using a slow crystal clock as the time base. The nominal setting is a 15 MHz fast clock against a 32768 Hz reference. At that setting the fast clock is ten times the 1.5 MHz serial bit rate, and the loop must keep the relative error under about 0.32%. That limit comes from allowing at most a third of a bit of drift over a 103-bit frame.

The block runs inside the fast-clock domain. The reference passes through a two-flop synchroniser and a rising-edge detector. The block then counts fast cycles over a window of `WIN_REFS` reference periods (32 by default, so the nominal count is 14648) and compares the total with a target count given on a port. A count below the tolerance band raises the trim code by one step. A count above the band lowers it by one step. A count inside the band leaves the code alone. The code is monotonic: a higher code gives a faster oscillator. Because the loop runs on every window, it follows slow drift from temperature and supply. A lock flag reports a run of in-band measurements.

Top module: `otc_trim_loop`

## Requirements
- R1: After synchronous reset, `trim_code` equals `TRIM_INIT`, and `locked`, `meas_count` and `meas_valid` are 0.
- R2: While `enable` is low, no measurement completes: `meas_valid` stays 0 and `trim_code` holds.
- R3: `meas_count` equals the number of fast-clock cycles between the reference rising edge that opens a window and the `WIN_REFS`-th rising edge after it. The closing edge also opens the next window, so consecutive windows share that edge.
- R4: `meas_valid` is a one-cycle pulse. It is high in the first cycle in which the new `meas_count`, `trim_code` and `locked` are visible.
- R5: A measurement with `meas_count < target_count - TOL` raises `trim_code` by 1.
- R6: A measurement with `meas_count > target_count + TOL` lowers `trim_code` by 1.
- R7: A measurement inside the band, boundaries included, leaves `trim_code` unchanged.
- R8: At `TRIM_MAX` a raise request holds the code; it never wraps to 0.
- R9: At 0 a lower request holds the code; it never wraps to `TRIM_MAX`.
- R10: `locked` rises on the `LOCK_RUN`-th consecutive in-band measurement (2 by default). It clears on any out-of-band measurement.
- R11: `trim_code` changes only in a `meas_valid` cycle, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock being trimmed |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the measurement loop when high |
| ref_clk | input | 1 | Asynchronous slow reference clock |
| target_count | input | CNT_W | Expected fast cycles per window |
| trim_code | output | TRIM_W | Oscillator trim setting |
| locked | output | 1 | Run of in-band measurements reached |
| meas_count | output | CNT_W | Most recent window count |
| meas_valid | output | 1 | One-cycle pulse when a window closes |

## Verification
In the same cycle, the closing reference edge ends one window and opens the next, and the count must lose no cycle across that shared edge. The bench drives a reference whose half period depends on the live trim code, so windows close while the code is moving. Every count is then compared with the difference between logged edge times, and any slip shows up as a miscount of one. Saturation and the lock clearing also coincide with a window close. Targets out of reach push the code against each limit, and the bench judges the code, the count and the lock flag together at each pulse.

// File: rtl/otc_pkg.sv
package otc_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD  = 2'd0,
    DIR_RAISE = 2'd1,
    DIR_LOWER = 2'd2
  } trim_dir_e;

  // Classify a window count against an inclusive band [lo, hi].
  function automatic trim_dir_e judge_count(input logic [31:0] cnt,
                                            input logic [31:0] lo,
                                            input logic [31:0] hi);
    if (cnt < lo)      return DIR_RAISE;
    else if (cnt > hi) return DIR_LOWER;
    else               return DIR_HOLD;
  endfunction

endpackage

// File: rtl/otc_ref_sync.sv
module otc_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic rise_pulse
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q     <= '0;
      last_q     <= 1'b0;
      rise_pulse <= 1'b0;
    end else begin
      sync_q     <= {sync_q[SYNC_STAGES-2:0], ref_async};
      last_q     <= sync_q[SYNC_STAGES-1];
      rise_pulse <= sync_q[SYNC_STAGES-1] & ~last_q;
    end
  end
endmodule

// File: rtl/otc_window_counter.sv
module otc_window_counter #(
  parameter int CNT_W    = 16,
  parameter int WIN_REFS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             ref_rise,
  output logic             win_done,
  output logic [CNT_W-1:0] win_cycles
);
  localparam int REF_W = $clog2(WIN_REFS + 1);
  localparam logic [REF_W-1:0] LAST_REF = REF_W'(WIN_REFS - 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};

  logic             armed_q;
  logic [REF_W-1:0] refs_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign cnt_inc    = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
  assign win_done   = enable & ref_rise & armed_q & (refs_q == LAST_REF);
  assign win_cycles = cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      armed_q <= 1'b0;
      refs_q  <= '0;
      cnt_q   <= '0;
    end else if (ref_rise) begin
      if (!armed_q || refs_q == LAST_REF) begin
        // opening edge, or closing edge that also opens the next window
        armed_q <= 1'b1;
        refs_q  <= '0;
        cnt_q   <= CNT_W'(1);
      end else begin
        refs_q  <= refs_q + 1'b1;
        cnt_q   <= cnt_inc;
      end
    end else if (armed_q) begin
      cnt_q <= cnt_inc;
    end
  end
endmodule

// File: rtl/otc_trim_step.sv
module otc_trim_step
  import otc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int TRIM_W    = 6,
  parameter int TOL       = 40,
  parameter int LOCK_RUN  = 2,
  parameter int TRIM_INIT = 2 ** (TRIM_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_done,
  input  logic [CNT_W-1:0]  win_cycles,
  input  logic [CNT_W-1:0]  target_count,
  output logic [TRIM_W-1:0] trim_code,
  output logic              locked,
  output logic [CNT_W-1:0]  meas_count,
  output logic              meas_valid
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};
  localparam int RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(LOCK_RUN);

  logic [31:0]      band_lo, band_hi;
  trim_dir_e        dir;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] run_next;

  always_comb begin
    band_hi = 32'(target_count) + 32'(TOL);
    band_lo = (32'(target_count) > 32'(TOL)) ? 32'(target_count) - 32'(TOL) : 32'd0;
    dir     = judge_count(32'(win_cycles), band_lo, band_hi);
    run_next = (run_q == RUN_FULL) ? run_q : run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trim_code  <= TRIM_W'(TRIM_INIT);
      locked     <= 1'b0;
      meas_count <= '0;
      meas_valid <= 1'b0;
      run_q      <= '0;
    end else begin
      meas_valid <= win_done;
      if (win_done) begin
        meas_count <= win_cycles;
        unique case (dir)
          DIR_RAISE: begin
            if (trim_code != TRIM_MAX) trim_code <= trim_code + 1'b1;
            run_q  <= '0;
            locked <= 1'b0;
          end
          DIR_LOWER: begin
            if (trim_code != '0) trim_code <= trim_code - 1'b1;
            run_q  <= '0;
            locked <= 1'b0;
          end
          default: begin
            run_q  <= run_next;
            locked <= (run_next == RUN_FULL);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/otc_trim_loop.sv
module otc_trim_loop #(
  parameter int CNT_W     = 16,
  parameter int TRIM_W    = 6,
  parameter int WIN_REFS  = 32,
  parameter int TOL       = 40,
  parameter int LOCK_RUN  = 2,
  parameter int TRIM_INIT = 2 ** (TRIM_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              ref_clk,
  input  logic [CNT_W-1:0]  target_count,
  output logic [TRIM_W-1:0] trim_code,
  output logic              locked,
  output logic [CNT_W-1:0]  meas_count,
  output logic              meas_valid
);
  logic             ref_rise;
  logic             win_done;
  logic [CNT_W-1:0] win_cycles;

  otc_ref_sync #(.SYNC_STAGES(2)) u_sync (
    .clk        (clk),
    .rst        (rst),
    .ref_async  (ref_clk),
    .rise_pulse (ref_rise)
  );

  otc_window_counter #(.CNT_W(CNT_W), .WIN_REFS(WIN_REFS)) u_win (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .ref_rise   (ref_rise),
    .win_done   (win_done),
    .win_cycles (win_cycles)
  );

  otc_trim_step #(
    .CNT_W(CNT_W), .TRIM_W(TRIM_W), .TOL(TOL),
    .LOCK_RUN(LOCK_RUN), .TRIM_INIT(TRIM_INIT)
  ) u_step (
    .clk          (clk),
    .rst          (rst),
    .win_done     (win_done),
    .win_cycles   (win_cycles),
    .target_count (target_count),
    .trim_code    (trim_code),
    .locked       (locked),
    .meas_count   (meas_count),
    .meas_valid   (meas_valid)
  );
endmodule

// File: rtl/otc_trim_loop_chk.sv
module otc_trim_loop_chk #(
  parameter int CNT_W  = 16,
  parameter int TRIM_W = 6,
  parameter int TOL    = 40
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic [CNT_W-1:0]  target_count,
  input logic [TRIM_W-1:0] trim_code,
  input logic              locked,
  input logic [CNT_W-1:0]  meas_count,
  input logic              meas_valid
);
  localparam logic [TRIM_W-1:0] TRIM_MAX = {TRIM_W{1'b1}};

  a_r4_valid_single_pulse: assert property (@(posedge clk) disable iff (rst)
    meas_valid |=> !meas_valid);

  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !meas_valid);

  a_r11_trim_moves_on_valid: assert property (@(posedge clk) disable iff (rst)
    (trim_code != $past(trim_code)) |-> meas_valid);

  a_r11_single_step: assert property (@(posedge clk) disable iff (rst)
    meas_valid |-> (trim_code == $past(trim_code)) ||
                   (trim_code == $past(trim_code) + 1'b1) ||
                   (trim_code == $past(trim_code) - 1'b1));

  a_r8_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    ($past(trim_code) == TRIM_MAX) |-> (trim_code != '0));

  a_r9_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    ($past(trim_code) == '0) |-> (trim_code != TRIM_MAX));

  a_r10_lock_rises_on_valid: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> meas_valid);

  a_r10_out_of_band_unlocks: assert property (@(posedge clk) disable iff (rst)
    (meas_valid && ((32'(meas_count) + 32'(TOL) < 32'($past(target_count))) ||
                    (32'(meas_count) > 32'($past(target_count)) + 32'(TOL))))
      |-> !locked);
endmodule

bind otc_trim_loop otc_trim_loop_chk #(
  .CNT_W(CNT_W), .TRIM_W(TRIM_W), .TOL(TOL)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .enable       (enable),
  .target_count (target_count),
  .trim_code    (trim_code),
  .locked       (locked),
  .meas_count   (meas_count),
  .meas_valid   (meas_valid)
);

// File: tb/otc_trim_loop_tb.sv
`timescale 1ns/1ps
module otc_trim_loop_tb;
  localparam int CNT_W = 12, TRIM_W = 4, WIN = 4, TOL = 4, RUN = 2, INIT = 8;
  localparam int TMAX = 15, BASE_HALF = 45;

  logic clk = 1'b0, rst = 1'b1, enable = 1'b0, ref_clk = 1'b0;
  logic [CNT_W-1:0]  target_count = 12'd400;
  logic [TRIM_W-1:0] trim_code;
  logic              locked, meas_valid;
  logic [CNT_W-1:0]  meas_count;

  otc_trim_loop #(.CNT_W(CNT_W), .TRIM_W(TRIM_W), .WIN_REFS(WIN), .TOL(TOL),
                  .LOCK_RUN(RUN), .TRIM_INIT(INIT)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .ref_clk(ref_clk),
    .target_count(target_count), .trim_code(trim_code), .locked(locked),
    .meas_count(meas_count), .meas_valid(meas_valid));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, cyc = 0, idle_valids = 0;
  bit gen_on = 0, log_on = 0, mon_on = 0, done = 0;
  int edge_q[$];

  task automatic check(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Oscillator model: reference half period in fast cycles grows with trim.
  initial begin
    int left = 0;
    forever begin
      @(negedge clk);
      if (!gen_on) begin
        ref_clk = 1'b0; left = 0;
      end else if (left == 0) begin
        ref_clk = ~ref_clk;
        if (ref_clk && log_on) edge_q.push_back(cyc);
        left = BASE_HALF + int'(trim_code) - 1;
      end else begin
        left--;
      end
    end
  end

  // Monitor: pops logged edges and compares every result with the model.
  initial begin
    int start_t = 0, end_t = 0, exp_cnt, m_trim = INIT, m_run = 0, m_lock = 0;
    bit have_start = 0;
    forever begin
      @(negedge clk);
      if (!enable && meas_valid) idle_valids++;
      if (mon_on && meas_valid) begin
        if (!have_start) begin start_t = edge_q.pop_front(); have_start = 1; end
        for (int i = 0; i < WIN; i++) end_t = edge_q.pop_front();
        exp_cnt = end_t - start_t;
        start_t = end_t;
        check(int'(meas_count), exp_cnt, "R3 window count");
        if (exp_cnt < int'(target_count) - TOL) begin
          if (m_trim < TMAX) m_trim++;           // R5 / R8
          m_run = 0; m_lock = 0;
        end else if (exp_cnt > int'(target_count) + TOL) begin
          if (m_trim > 0) m_trim--;              // R6 / R9
          m_run = 0; m_lock = 0;
        end else begin                           // R7
          if (m_run < RUN) m_run++;
          m_lock = (m_run == RUN) ? 1 : 0;
        end
        check(int'(trim_code), m_trim, "R5/R6/R7 trim step");
        check(int'(locked), m_lock, "R10 lock flag");
        @(negedge clk);
        check(int'(meas_valid), 0, "R4 valid pulse width");
      end
    end
  end

  task automatic wait_valids(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!meas_valid) @(negedge clk);
    end
  endtask

  task automatic set_target(input int t);
    @(negedge clk); while (!meas_valid) @(negedge clk);
    @(posedge clk); #1 target_count = CNT_W'(t);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(int'(trim_code), INIT, "R1 reset trim");
    check(int'(locked), 0, "R1 reset locked");
    check(int'(meas_count), 0, "R1 reset count");
    check(int'(meas_valid), 0, "R1 reset valid");

    // R2: reference runs while disabled
    gen_on = 1;
    repeat (1500) @(negedge clk);
    check(idle_valids, 0, "R2 no measurement while disabled");
    check(int'(trim_code), INIT, "R2 trim holds while disabled");
    gen_on = 0;
    repeat (10) @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    edge_q.delete();
    log_on = 1; mon_on = 1; gen_on = 1;

    // R5/R6/R10: converge from above to trim 5 and lock
    wait_valids(8);
    check(int'(trim_code), 5, "R6 converged trim");
    check(int'(locked), 1, "R10 locked after in-band run");

    // R7 band edges: count 400 sits on lower then upper boundary
    set_target(404);
    wait_valids(3);
    check(int'(trim_code), 5, "R7 lower band edge holds");
    set_target(396);
    wait_valids(3);
    check(int'(trim_code), 5, "R7 upper band edge holds");

    // R8: unreachable high target
    set_target(2000);
    wait_valids(16);
    check(int'(trim_code), TMAX, "R8 saturate at max");
    check(int'(locked), 0, "R10 unlocked out of band");

    // R9: unreachable low target
    set_target(100);
    wait_valids(20);
    check(int'(trim_code), 0, "R9 saturate at zero");

    set_target(400);
    wait_valids(10);
    check(int'(trim_code), 5, "R5 reconverged from below");
    check(int'(locked), 1, "R10 relocked");
    finish_run();
  end
endmodule